// File: doc/BRIEF.md
# Reference-Locked Oscillator Trim Calibrator

This block tunes a local fast oscillator against a slow, accurate reference clock. It works entirely in the fast-clock domain. A free-running counter advances once per fast cycle. The reference arrives as a single-cycle edge strobe that has already been synchronized. The strobe is prescaled by four, so one measurement window spans four reference periods. At the close of each window the counter is captured, and the previous capture is subtracted from it. The result is the number of fast cycles in the window.

After a start pulse, the calibrator loads an initial trim code and latches the target count. It then loops through measure, compare and step. A window that is short of the target raises the trim by one code. A window that is long lowers it by one code. The loop ends only when a window equals the target exactly. The first window after start runs from a capture base of zero, so its result is thrown away. An iteration limit stops a loop that never converges. This happens when the trim sticks at an end of its range, or when it toggles between two neighbouring codes that straddle the target. The limit ends the run with an error flag.

For example, a 2.048 MHz oscillator checked against a 32768 Hz reference uses a target of 250.

Top module: `osc_trim_cal`

## Requirements
- R1: After reset, `trim` is 0 and `busy`, `done` and `err` are all low.
- R2: A `start` pulse sampled while `busy` is low has these effects, all visible after that same clock edge: `trim` takes `trim_init`, `target` is latched, `busy` goes high, and `done` and `err` clear.
- R3: One measurement equals the number of fast cycles between two consecutive captures. A capture is taken on every fourth sampled `ref_edge` strobe during a run. The subtraction is modulo 2^CNT_W, so a counter wrap between captures still gives the true count.
- R4: The first measurement after a start changes neither `trim` nor any flag.
- R5: A measurement below the latched target raises `trim` by one. A measurement above it lowers `trim` by one. The new code appears after the second clock edge, counting the edge that samples the window-closing strobe as the first.
- R6: A measurement equal to the latched target sets `done`, drops `busy` and leaves `trim` unchanged, with the same timing as R5. `done` stays high until the next start.
- R7: The trim saturates at both ends. A step up from 255 leaves it at 255, and a step down from 0 leaves it at 0. Each such attempt still counts as an iteration.
- R8: The run stops after MAX_ITER mismatched measurements, counting only measurements that are not discarded. The last step is applied, then `err` rises and `busy` drops. A MAX_ITER of 0 disables the limit.
- R9: A `start` pulse while `busy` is high is ignored, and the running calibration continues unchanged.
- R10: While idle, `ref_edge` strobes have no effect: `trim`, `done` and `err` hold their values.
- R11: At most one of `busy`, `done` and `err` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to begin a calibration |
| ref_edge | input | 1 | Synchronized single-cycle strobe, one per reference edge |
| target | input | CNT_W | Wanted fast-cycle count per four reference periods |
| trim_init | input | TRIM_W | Trim code loaded at start |
| trim | output | TRIM_W | Oscillator trim code |
| busy | output | 1 | Calibration in progress |
| done | output | 1 | Exact match reached |
| err | output | 1 | Iteration limit reached without a match |

## Verification
The bench models the oscillator itself. Each reference spacing is set to 50 plus the current trim code, taken from the bench's own trim model, so each window is known exactly in advance. Every fourth strobe closes a window. When the driver emits that strobe, it computes the expected `trim`, `busy`, `done` and `err` from the requirements. It queues them with a due cycle two clock edges after the sampling edge: one edge for the registered measurement and one for the trim and state registers. A monitor compares the queue's head on the falling edge of exactly that cycle, and reports any entry whose due cycle has passed unchecked. The start response is due after one edge and is checked directly on the next falling edge.

// File: rtl/osc_cal_pkg.sv
`timescale 1ns/1ps
package osc_cal_pkg;

  typedef enum logic [1:0] {
    CAL_IDLE = 2'd0,
    CAL_RUN  = 2'd1,
    CAL_LOCK = 2'd2,
    CAL_FAIL = 2'd3
  } cal_state_t;

  typedef enum logic [1:0] {
    CMP_EQ   = 2'd0,
    CMP_LOW  = 2'd1,
    CMP_HIGH = 2'd2
  } cmp_res_t;

endpackage

// File: rtl/ref_prescaler.sv
`timescale 1ns/1ps
module ref_prescaler #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic edge_in,
  output logic tick
);

  localparam int DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);
  localparam logic [DIV_W-1:0] ONE  = DIV_W'(1);

  logic [DIV_W-1:0] ecnt_q, ecnt_d;
  logic             ecnt_en;

  assign tick    = en & edge_in & (ecnt_q == LAST);
  assign ecnt_en = clr | (en & edge_in);

  always_comb begin
    ecnt_d = ecnt_q;
    if (clr)       ecnt_d = '0;
    else if (tick) ecnt_d = '0;
    else           ecnt_d = ecnt_q + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ecnt_q <= '0;
    else if (ecnt_en) ecnt_q <= ecnt_d;
  end

endmodule

// File: rtl/span_meter.sv
`timescale 1ns/1ps
module span_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  output logic             meas_vld,
  output logic [CNT_W-1:0] meas
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] base_q, base_d;
  logic [CNT_W-1:0] meas_q, meas_d;
  logic             vld_q, vld_d;
  logic             cap;
  logic             cnt_en;

  assign cap    = en & tick & ~clr;
  assign cnt_en = clr | en;

  always_comb begin
    cnt_d  = clr ? '0 : cnt_q + ONE;
    base_d = base_q;
    meas_d = meas_q;
    if (clr) begin
      base_d = '0;
    end else if (cap) begin
      base_d = cnt_q;
      meas_d = cnt_q - base_q;
    end
    vld_d = cap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      meas_q <= '0;
    end else if (clr | cap) begin
      base_q <= base_d;
      meas_q <= meas_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign meas_vld = vld_q;
  assign meas     = meas_q;

endmodule

// File: rtl/trim_stepper.sv
`timescale 1ns/1ps
module trim_stepper
  import osc_cal_pkg::*;
#(
  parameter int TRIM_W   = 8,
  parameter int CNT_W    = 16,
  parameter int MAX_ITER = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TRIM_W-1:0] trim_init,
  input  logic [CNT_W-1:0]  target,
  input  logic              meas_vld,
  input  logic [CNT_W-1:0]  meas,
  output logic              launch,
  output logic [CNT_W-1:0]  tgt_lat,
  output logic [TRIM_W-1:0] trim,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int ITER_W = (MAX_ITER > 1) ? $clog2(MAX_ITER + 1) : 1;
  localparam logic [TRIM_W-1:0] TRIM_TOP = '1;
  localparam logic [TRIM_W-1:0] TRIM_ONE = TRIM_W'(1);
  localparam logic [ITER_W-1:0] ITER_ONE = ITER_W'(1);

  cal_state_t        state_q, state_d;
  logic [TRIM_W-1:0] trim_q, trim_d, trim_step;
  logic [CNT_W-1:0]  tgt_q, tgt_d;
  logic [ITER_W-1:0] iter_q, iter_d;
  logic              first_q, first_d;
  logic              limit_hit;
  logic              judge;
  cmp_res_t          cmp;

  assign launch = start & (state_q != CAL_RUN);
  assign judge  = (state_q == CAL_RUN) & meas_vld & ~first_q;

  always_comb begin
    if (meas == tgt_q)     cmp = CMP_EQ;
    else if (meas < tgt_q) cmp = CMP_LOW;
    else                   cmp = CMP_HIGH;
  end

  always_comb begin
    trim_step = trim_q;
    unique case (cmp)
      CMP_LOW:  if (trim_q != TRIM_TOP) trim_step = trim_q + TRIM_ONE;
      CMP_HIGH: if (trim_q != '0)       trim_step = trim_q - TRIM_ONE;
      default:  trim_step = trim_q;
    endcase
  end

  generate
    if (MAX_ITER > 0) begin : g_limit
      localparam logic [ITER_W-1:0] ITER_LAST = ITER_W'(MAX_ITER - 1);
      assign limit_hit = (iter_q == ITER_LAST);
    end else begin : g_nolimit
      assign limit_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    state_d = state_q;
    trim_d  = trim_q;
    tgt_d   = tgt_q;
    iter_d  = iter_q;
    first_d = first_q;
    if (launch) begin
      state_d = CAL_RUN;
      trim_d  = trim_init;
      tgt_d   = target;
      iter_d  = '0;
      first_d = 1'b1;
    end else if ((state_q == CAL_RUN) && meas_vld) begin
      if (first_q) begin
        first_d = 1'b0;
      end else if (cmp == CMP_EQ) begin
        state_d = CAL_LOCK;
      end else begin
        trim_d = trim_step;
        iter_d = iter_q + ITER_ONE;
        if (limit_hit) state_d = CAL_FAIL;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CAL_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trim_q  <= '0;
      tgt_q   <= '0;
      iter_q  <= '0;
      first_q <= 1'b0;
    end else if (launch | judge | meas_vld) begin
      trim_q  <= trim_d;
      tgt_q   <= tgt_d;
      iter_q  <= iter_d;
      first_q <= first_d;
    end
  end

  assign tgt_lat = tgt_q;
  assign trim    = trim_q;
  assign busy    = (state_q == CAL_RUN);
  assign done    = (state_q == CAL_LOCK);
  assign err     = (state_q == CAL_FAIL);

endmodule

// File: rtl/osc_trim_cal.sv
`timescale 1ns/1ps
module osc_trim_cal #(
  parameter int TRIM_W   = 8,
  parameter int CNT_W    = 16,
  parameter int REF_DIV  = 4,
  parameter int MAX_ITER = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ref_edge,
  input  logic [CNT_W-1:0]  target,
  input  logic [TRIM_W-1:0] trim_init,
  output logic [TRIM_W-1:0] trim,
  output logic              busy,
  output logic              done,
  output logic              err
);

  logic             launch;
  logic             win_tick;
  logic             meas_vld;
  logic [CNT_W-1:0] meas_cnt;
  logic [CNT_W-1:0] tgt_lat;

  ref_prescaler #(
    .DIV (REF_DIV)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (launch),
    .en      (busy),
    .edge_in (ref_edge),
    .tick    (win_tick)
  );

  span_meter #(
    .CNT_W (CNT_W)
  ) u_meter (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (launch),
    .en       (busy),
    .tick     (win_tick),
    .meas_vld (meas_vld),
    .meas     (meas_cnt)
  );

  trim_stepper #(
    .TRIM_W   (TRIM_W),
    .CNT_W    (CNT_W),
    .MAX_ITER (MAX_ITER)
  ) u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .trim_init (trim_init),
    .target    (target),
    .meas_vld  (meas_vld),
    .meas      (meas_cnt),
    .launch    (launch),
    .tgt_lat   (tgt_lat),
    .trim      (trim),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

endmodule

// File: rtl/osc_trim_cal_chk.sv
`timescale 1ns/1ps
module osc_trim_cal_chk #(
  parameter int TRIM_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [TRIM_W-1:0] trim_init,
  input logic [TRIM_W-1:0] trim,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              meas_vld,
  input logic [CNT_W-1:0]  meas_cnt,
  input logic [CNT_W-1:0]  tgt_lat
);

  localparam logic [TRIM_W-1:0] T1 = TRIM_W'(1);

  // R11
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done, err}));

  // R5
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |->
      ((trim == $past(trim)) || (trim == $past(trim) + T1) || (trim == $past(trim) - T1)));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(start)) |-> $stable(trim));

  // R2
  launch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (trim == $past(trim_init)));

  // R6
  lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(meas_vld && (meas_cnt == tgt_lat)));

  // R8
  fail_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(meas_vld && (meas_cnt != tgt_lat)));

endmodule

bind osc_trim_cal osc_trim_cal_chk #(
  .TRIM_W (TRIM_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .trim_init (trim_init),
  .trim      (trim),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .meas_vld  (meas_vld),
  .meas_cnt  (meas_cnt),
  .tgt_lat   (tgt_lat)
);

// File: tb/osc_trim_cal_bench.sv
`timescale 1ns/1ps
module osc_trim_cal_bench;

  localparam int CW   = 11;
  localparam int MAXI = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          ref_i = 1'b0;
  logic [CW-1:0] target_i = '0;
  logic [7:0]    trim_init_i = '0;
  logic [7:0]    trim_o;
  logic          busy_o, done_o, err_o;

  int  cyc = 0;
  int  n_run = 0;
  int  n_fail = 0;
  bit  ended = 0;

  typedef struct {
    int         due;
    logic [7:0] trim;
    logic       busy;
    logic       done;
    logic       err;
    string      req;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  osc_trim_cal #(
    .TRIM_W   (8),
    .CNT_W    (CW),
    .REF_DIV  (4),
    .MAX_ITER (MAXI)
  ) u_osc_trim_cal (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .ref_edge  (ref_i),
    .target    (target_i),
    .trim_init (trim_init_i),
    .trim      (trim_o),
    .busy      (busy_o),
    .done      (done_o),
    .err       (err_o)
  );

  task automatic compare(input string req, input logic [7:0] t, input logic b,
                         input logic d, input logic e);
    n_run++;
    if (trim_o !== t || busy_o !== b || done_o !== d || err_o !== e) begin
      n_fail++;
      $display("FAIL %s: trim=%0d busy=%0b done=%0b err=%0b expected trim=%0d busy=%0b done=%0b err=%0b",
               req, trim_o, busy_o, done_o, err_o, t, b, d, e);
    end
  endtask

  task automatic push(input int due, input int t, input logic b, input logic d,
                      input logic e, input string req);
    exp_t it;
    it.due = due; it.trim = 8'(t); it.busy = b; it.done = d; it.err = e; it.req = req;
    sb.push_back(it);
  endtask

  // Scoreboard monitor: compares each queued item on its due cycle
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due < cyc) begin
      n_run++; n_fail++;
      $display("FAIL %s: result not observed at cycle %0d (actual cycle %0d, expected cycle %0d)",
               sb[0].req, sb[0].due, cyc, sb[0].due);
      void'(sb.pop_front());
    end
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t it;
      it = sb.pop_front();
      compare(it.req, it.trim, it.busy, it.done, it.err);
    end
  end

  // Driver: models the oscillator (spacing = 50 + trim) and predicts results
  task automatic run_cal(input int init, input int tgt, input bit inject, input string tag);
    int mt, iter, sum, k, p;
    bit first, fin;
    trim_init_i = 8'(init);
    target_i    = CW'(tgt);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    compare({tag, " R2 launch"}, 8'(init), 1'b1, 1'b0, 1'b0);
    repeat (10) @(negedge clk);
    mt = init; first = 1; iter = 0; sum = 0; k = 0; fin = 0;
    while (!fin) begin
      ref_i = 1'b1;
      k++;
      if (k % 4 == 0) begin
        if (first) begin
          first = 0;
          push(cyc + 2, mt, 1'b1, 1'b0, 1'b0, {tag, " R4 discard"});
        end else if (sum == tgt) begin
          fin = 1;
          push(cyc + 2, mt, 1'b0, 1'b1, 1'b0, {tag, " R6 match"});
        end else begin
          if (sum < tgt) begin if (mt < 255) mt++; end
          else           begin if (mt > 0)   mt--; end
          iter++;
          if (iter == MAXI) begin
            fin = 1;
            push(cyc + 2, mt, 1'b0, 1'b0, 1'b1, {tag, " R8 limit"});
          end else begin
            push(cyc + 2, mt, 1'b1, 1'b0, 1'b0, {tag, " R3 R5 R7 step"});
          end
        end
        sum = 0;
      end
      @(negedge clk); ref_i = 1'b0;
      p = 50 + mt;
      sum += p;
      for (int w = 1; w < p; w++) begin
        if (inject && k == 6 && w == 20) begin
          trim_init_i = 8'd7; start_i = 1'b1;   // R9: start while busy
        end else if (start_i) begin
          start_i = 1'b0; trim_init_i = 8'(init);
        end
        @(negedge clk);
      end
    end
    repeat (6) @(negedge clk);
    if (sb.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL %s: %0d results pending, expected 0", tag, sb.size());
      sb.delete();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1 reset", 8'd0, 1'b0, 1'b0, 1'b0);

    // R5 upward convergence, R9 ignored restart, R3 windows straddle counter wrap
    run_cal(100, 4 * (50 + 105), 1'b1, "up R9");
    compare("R6 lock trim up", 8'd105, 1'b0, 1'b1, 1'b0);
    // R5 downward convergence
    run_cal(120, 4 * (50 + 115), 1'b0, "down");
    compare("R6 lock trim down", 8'd115, 1'b0, 1'b1, 1'b0);
    // R4 R6 immediate match
    run_cal(110, 4 * (50 + 110), 1'b0, "exact");
    // R10 strobes while idle
    for (int j = 0; j < 8; j++) begin
      @(negedge clk); ref_i = 1'b1;
      @(negedge clk); ref_i = 1'b0;
      repeat (58) @(negedge clk);
    end
    compare("R10 idle strobes", 8'd110, 1'b0, 1'b1, 1'b0);
    // R8 toggling between neighbours
    run_cal(100, 4 * (50 + 100) + 2, 1'b0, "toggle");
    compare("R8 toggle end", 8'd100, 1'b0, 1'b0, 1'b1);
    // R7 saturation high and low
    run_cal(254, 1600, 1'b0, "sat_hi");
    compare("R7 sat high", 8'd255, 1'b0, 1'b0, 1'b1);
    run_cal(1, 4, 1'b0, "sat_lo");
    compare("R7 sat low", 8'd0, 1'b0, 1'b0, 1'b1);

    if (!ended) begin
      ended = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish (actual cycle %0d, expected below 150000)", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule